// File: doc/BRIEF.md
# Start-Bit Framed ADC Serial Target

This block models the serial side of an eight-channel, 10-bit sampling converter, so that a host controller's serial master can be checked against it. It runs on a fast system clock and oversamples the host's chip-select, serial clock and data-in lines through a short synchronizer. Every bit it reads or writes is tied to a detected rising edge of the serial clock. The actual analog conversion is not modelled. A 10-bit value on a parallel `sample` input stands in for it.

With chip-select low, the block ignores any zeros until the first 1. That bit is the start bit and opens a frame. The next seven bits hold the command fields. After the eighth edge of the frame, the block decodes the command, latches the sample input and raises a strobe for one serial-clock period. It then shifts out the ten result bits, MSB first, on the following edges. A frame lasts sixteen serial-clock edges counted from the start bit, so the seventeenth edge may already carry the next start bit while the tail of the previous result is still being shifted out.

Raising chip-select at any point abandons the frame. It also clears the output shifter, and it drops the data-out enable, which a pad would use to tri-state the line.

Top module: `adc_serial_target`

## Requirements
- R1: After reset, `dout_oe`, `dout` and `sstrb` are 0 and the decoded fields `chan`, `unipolar`, `single_ended` and `pwr_mode` are all 0.
- R2: While chip-select is low and no frame is open, a 0 on DIN at a rising SCLK edge has no effect. The first 1 opens a frame, and that edge counts as edge 1.
- R3: The command is the start bit followed by seven bits, MSB first: channel number (3 bits), unipolar flag, single-ended flag and power mode (2 bits). The decoded fields update only at frame edge 8. Command 0xFF therefore decodes as channel 7, unipolar, single-ended, power mode 3 (stay powered).
- R4: `sstrb` is high from frame edge 8 until frame edge 9, which is exactly one SCLK period. It is low at all other times.
- R5: The `sample` value present at frame edge 8 is latched. Later changes to `sample` have no effect on that result. Its bits appear on `dout` MSB first, bit 9 after frame edge 9 through bit 0 after frame edge 18; a full-scale sample 0x3FF gives ten 1s.
- R6: While chip-select is low, `dout` is 0 whenever no result bit is being presented, including during the strobe period.
- R7: While chip-select is high (after the synchronizer), `dout_oe`, `dout` and `sstrb` are 0. Raising chip-select mid-frame abandons the frame and clears any pending result, so the next frame needs a fresh start bit.
- R8: DIN is ignored on frame edges 9 through 16, even when it is 1. Frame edge 17 is again hunted for a start bit, so conversions can follow back to back every 16 SCLK edges.
- R9: `dout`, `sstrb` and the decoded fields change only in response to a rising SCLK edge, or to chip-select going high. DIN activity while SCLK is idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select from the host, active low |
| sclk | input | 1 | Serial clock from the host; data is taken and launched on its rising edge |
| din | input | 1 | Serial command data from the host |
| sample | input | SAMPLE_W (10) | Conversion value to report, latched at frame edge 8 |
| dout | output | 1 | Serial result data, MSB first |
| dout_oe | output | 1 | High while selected; low means the data line should be released |
| sstrb | output | 1 | One-SCLK-period strobe preceding the result MSB |
| chan | output | 3 | Decoded channel number of the last command |
| unipolar | output | 1 | Decoded unipolar (1) or bipolar (0) flag |
| single_ended | output | 1 | Decoded single-ended (1) or differential (0) flag |
| pwr_mode | output | 2 | Decoded power-mode field |

## Verification
On every system clock, the bound checker enforces several rules. Outputs are quiet while the block is deselected. The strobe lasts only until the next detected serial edge. Data out is low while the strobe is high. Neither outputs nor decoded fields move between serial edges.

Some properties depend on a whole frame, and only the directed scenarios can show them. These are the start-bit hunt past leading zeros, the field positions of the command, the MSB-first bit order, and latching of the sample at edge 8. The same holds for ignoring DIN during the back half of a frame, back-to-back framing at edge 17, and restarting cleanly after an abandoned frame.

// File: rtl/adc_tgt_pkg.sv
package adc_tgt_pkg;

    // Command fields that follow the start bit, MSB first on the wire.
    typedef struct packed {
        logic [2:0] chan;
        logic       unipolar;
        logic       single;
        logic [1:0] pwr;
    } cfg_t;

    localparam int CFG_BITS = $bits(cfg_t);
    localparam int CMD_BITS = CFG_BITS + 1;   // start bit plus fields

endpackage

// File: rtl/adc_tgt_sync.sv
module adc_tgt_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RESET_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/adc_tgt_cmd_parser.sv
module adc_tgt_cmd_parser
    import adc_tgt_pkg::*;
#(
    parameter int FRAME_EDGES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,     // qualified rising SCLK edge
    input  logic active_i,   // chip-select asserted
    input  logic din_i,
    output logic done_o,     // command complete on this edge
    output cfg_t cfg_o
);

    localparam int            CW       = $clog2(FRAME_EDGES + 1);
    localparam int            SH_W     = CFG_BITS - 1;
    localparam logic [CW-1:0] LAST_EDGE = CW'(FRAME_EDGES);
    localparam logic [CW-1:0] CMD_EDGE  = CW'(CMD_BITS - 1);

    typedef struct packed {
        logic [CW-1:0]   cnt;    // edges seen in this frame, 0 = hunting
        logic [SH_W-1:0] shreg;  // field bits gathered after the start bit
        cfg_t            cfg;
    } state_t;

    state_t state_d, state_q;
    logic   done_d;

    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        if (!active_i) begin
            state_d.cnt   = '0;
            state_d.shreg = '0;
        end else if (edge_i) begin
            if (state_q.cnt == '0 || state_q.cnt == LAST_EDGE) begin
                state_d.cnt   = din_i ? CW'(1) : '0;
                state_d.shreg = '0;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
                if (state_q.cnt < CMD_EDGE) begin
                    state_d.shreg = {state_q.shreg[SH_W-2:0], din_i};
                end
                if (state_q.cnt == CMD_EDGE) begin
                    done_d        = 1'b1;
                    state_d.cfg   = cfg_t'({state_q.shreg, din_i});
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign done_o = done_d;
    assign cfg_o  = state_q.cfg;

endmodule

// File: rtl/adc_tgt_shifter.sv
module adc_tgt_shifter #(
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                edge_i,
    input  logic                active_i,
    input  logic                load_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                dout_o,
    output logic                strobe_o
);

    localparam int            LW       = $clog2(SAMPLE_W + 2);
    localparam logic [LW-1:0] LOAD_CNT = LW'(SAMPLE_W + 1);

    typedef struct packed {
        logic [LW-1:0]       left;   // strobe period plus bits still to present
        logic [SAMPLE_W-1:0] sr;
        logic                dout;
        logic                strobe;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!active_i) begin
            state_d = '0;
        end else if (edge_i) begin
            if (load_i) begin
                state_d.sr     = sample_i;
                state_d.left   = LOAD_CNT;
                state_d.strobe = 1'b1;
                state_d.dout   = 1'b0;
            end else if (state_q.left > LW'(1)) begin
                state_d.dout   = state_q.sr[SAMPLE_W-1];
                state_d.sr     = {state_q.sr[SAMPLE_W-2:0], 1'b0};
                state_d.left   = state_q.left - 1'b1;
                state_d.strobe = 1'b0;
            end else begin
                state_d.dout   = 1'b0;
                state_d.strobe = 1'b0;
                state_d.left   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dout_o   = state_q.dout;
    assign strobe_o = state_q.strobe;

endmodule

// File: rtl/adc_serial_target.sv
module adc_serial_target
    import adc_tgt_pkg::*;
#(
    parameter int SAMPLE_W    = 10,
    parameter int FRAME_EDGES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                din,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                dout,
    output logic                dout_oe,
    output logic                sstrb,
    output logic [2:0]          chan,
    output logic                unipolar,
    output logic                single_ended,
    output logic [1:0]          pwr_mode
);

    typedef struct packed {
        logic sclk_prev;
        logic oe;
    } state_t;

    state_t state_d, state_q;
    logic   cs_n_s, sclk_s, din_s;
    logic   sclk_rise;
    logic   cmd_done;
    cfg_t   cfg;

    adc_tgt_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b100)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({cs_n, sclk, din}),
        .q_o  ({cs_n_s, sclk_s, din_s})
    );

    always_comb begin
        state_d.sclk_prev = sclk_s;
        state_d.oe        = !cs_n_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sclk_rise = sclk_s && !state_q.sclk_prev && !cs_n_s;

    adc_tgt_cmd_parser #(
        .FRAME_EDGES(FRAME_EDGES)
    ) parser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_i  (sclk_rise),
        .active_i(!cs_n_s),
        .din_i   (din_s),
        .done_o  (cmd_done),
        .cfg_o   (cfg)
    );

    adc_tgt_shifter #(
        .SAMPLE_W(SAMPLE_W)
    ) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_i  (sclk_rise),
        .active_i(!cs_n_s),
        .load_i  (cmd_done),
        .sample_i(sample),
        .dout_o  (dout),
        .strobe_o(sstrb)
    );

    assign dout_oe      = state_q.oe;
    assign chan         = cfg.chan;
    assign unipolar     = cfg.unipolar;
    assign single_ended = cfg.single;
    assign pwr_mode     = cfg.pwr;

endmodule

// File: rtl/adc_serial_target_chk.sv
module adc_serial_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rise,
    input logic       cs_n_s,
    input logic       dout,
    input logic       dout_oe,
    input logic       sstrb,
    input logic [2:0] chan
);

    AST_STROBE_SINGLE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (sstrb && rise) |=> !sstrb); // R4

    AST_STROBE_DOUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sstrb |-> !dout); // R6

    AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (!dout && !sstrb)); // R7

    AST_HOLD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !cs_n_s) |=> ($stable(dout) && $stable(sstrb))); // R9

    AST_FIELDS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(chan)); // R3

endmodule

bind adc_serial_target adc_serial_target_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (sclk_rise),
    .cs_n_s (cs_n_s),
    .dout   (dout),
    .dout_oe(dout_oe),
    .sstrb  (sstrb),
    .chan   (chan)
);

// File: tb/adc_serial_target_tb_top.sv
module adc_serial_target_tb_top;

    localparam int HALF = 4;   // system clocks per SCLK half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic [9:0] sample = '0;
    logic       dout, dout_oe, sstrb, unipolar, single_ended;
    logic [2:0] chan;
    logic [1:0] pwr_mode;

    int   checks = 0;
    int   errors = 0;
    logic obs_d, obs_s;

    always #2.5 clk = ~clk;

    adc_serial_target dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .din         (din),
        .sample      (sample),
        .dout        (dout),
        .dout_oe     (dout_oe),
        .sstrb       (sstrb),
        .chan        (chan),
        .unipolar    (unipolar),
        .single_ended(single_ended),
        .pwr_mode    (pwr_mode)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One SCLK period; outputs are sampled just before the rising edge.
    task automatic tick(input logic b);
        din = b;
        repeat (HALF) @(negedge clk);
        obs_d = dout;
        obs_s = sstrb;
        sclk  = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk  = 1'b0;
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk);
        cs_n = v;
        repeat (8) @(negedge clk);
    endtask

    // Expected outputs seen before frame-relative edge e, command ending at edge c.
    task automatic expect_at(input int e, input int c, input logic [9:0] s,
                             output logic d, output logic st);
        d  = 1'b0;
        st = 1'b0;
        if (e == c + 1) st = 1'b1;
        else if (e >= c + 2 && e <= c + 11) d = s[9 - (e - c - 2)];
    endtask

    task automatic chk_fields(input string tag, input logic [7:0] cmd);
        chk("R3", {tag, " chan"}, chan, cmd[6:4]);
        chk("R3", {tag, " unipolar"}, unipolar, cmd[3]);
        chk("R3", {tag, " single_ended"}, single_ended, cmd[2]);
        chk("R3", {tag, " pwr_mode"}, pwr_mode, cmd[1:0]);
    endtask

    task automatic chk_released(input string tag);
        chk("R7", {tag, " dout_oe released"}, dout_oe, 0);
        chk("R7", {tag, " dout released"}, dout, 0);
        chk("R7", {tag, " sstrb released"}, sstrb, 0);
    endtask

    task automatic t_reset();
        chk("R1", "reset dout_oe", dout_oe, 0);
        chk("R1", "reset dout", dout, 0);
        chk("R1", "reset sstrb", sstrb, 0);
        chk("R1", "reset chan", chan, 0);
        chk("R1", "reset flags", {unipolar, single_ended, pwr_mode}, 0);
    endtask

    task automatic run_frame(input string tag, input int nlead, input logic [7:0] cmd,
                             input logic [9:0] smp, input logic fill, input int hold_e);
        int   c = nlead + 8;
        logic ed, es;
        sample = smp;
        set_cs(1'b0);
        chk("R7", {tag, " dout_oe when selected"}, dout_oe, 1);
        for (int e = 1; e <= c + 12; e++) begin
            logic b;
            if (e <= nlead) b = 1'b0;
            else if (e <= c) b = cmd[7 - (e - nlead - 1)];
            else if (e <= nlead + 16) b = fill;   // R8: ignored part of frame
            else b = 1'b0;
            tick(b);
            expect_at(e, c, smp, ed, es);
            chk((e >= c + 2 && e <= c + 11) ? "R5" : "R6", $sformatf("%s dout before edge %0d", tag, e), obs_d, ed);
            chk("R4", $sformatf("%s sstrb before edge %0d", tag, e), obs_s, es);
            if (e == c + 1) begin
                chk_fields(tag, cmd);
                if (nlead > 0) chk("R2", {tag, " start found after zeros"}, obs_s, 1);
            end
            if (e == c) sample = ~smp;   // R5: late change must not matter
            if (e == hold_e) begin
                repeat (20) begin
                    @(negedge clk);
                    din = ~din;
                end
                expect_at(e + 1, c, smp, ed, es);
                chk("R9", {tag, " dout held while SCLK idle"}, dout, ed);
                chk("R9", {tag, " sstrb held while SCLK idle"}, sstrb, es);
                chk("R9", {tag, " chan held while SCLK idle"}, chan, cmd[6:4]);
            end
        end
        if (fill) chk_fields({tag, " R8 ones after command ignored"}, cmd);
        set_cs(1'b1);
        chk_released(tag);
    endtask

    task automatic t_back_to_back(input logic [7:0] ca, input logic [9:0] sa,
                                  input logic [7:0] cb, input logic [9:0] sb);
        logic ed, es;
        sample = sa;
        set_cs(1'b0);
        for (int e = 1; e <= 36; e++) begin
            logic b;
            if (e <= 8) b = ca[8 - e];
            else if (e <= 16) b = 1'b1;           // R8: ignored even though 1
            else if (e <= 24) b = cb[24 - e];
            else b = 1'b0;
            tick(b);
            if (e <= 20) expect_at(e, 8, sa, ed, es);
            else expect_at(e, 24, sb, ed, es);
            chk("R8", $sformatf("b2b dout before edge %0d", e), obs_d, ed);
            chk("R8", $sformatf("b2b sstrb before edge %0d", e), obs_s, es);
            if (e == 9) chk_fields("b2b first", ca);
            if (e == 17) chk_fields("b2b R8 held through ignored edges", ca);
            if (e == 25) chk_fields("b2b second", cb);
            if (e == 8) sample = sb;
            if (e == 24) sample = 10'h000;
        end
        set_cs(1'b1);
        chk_released("b2b");
    endtask

    task automatic t_abort();
        sample = 10'h3FF;
        set_cs(1'b0);
        for (int e = 1; e <= 12; e++) tick((e <= 8) ? 1'b1 : 1'b0);
        chk("R5", "abort result bit shown before drop", obs_d, 1);
        set_cs(1'b1);
        chk_released("abort mid-result");
        set_cs(1'b0);
        tick(1'b1);
        tick(1'b0);
        tick(1'b1);
        set_cs(1'b1);
        chk_released("abort mid-command");
        run_frame("restart", 0, 8'h8C, 10'h155, 1'b0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        t_reset();
        run_frame("fullscale", 3, 8'hFF, 10'h3FF, 1'b0, 0);
        run_frame("mixed", 0, 8'hA5, 10'h2A5, 1'b1, 11);
        t_back_to_back(8'hB6, 10'h1C3, 8'hD9, 10'h0F0);
        t_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule